// File: doc/BRIEF.md
# Wake-Up Edge Controller

The controller samples a set of asynchronous wake-up lines, resynchronizes each one, and compares every line with its value one clock earlier to find rising and falling transitions. A per-line polarity bit chosen by software picks which transition counts. When the chosen transition appears, the line's pending flag is latched and held, and a single registered request output reports that at least one flag is pending. That output can be used as a wake-up or interrupt request.

Software reaches the block through a plain synchronous register port. It has an address, a write strobe, write data and combinational read data. There is no valid/ready handshake: every write is accepted on the clock edge where the strobe is high, and there is no back-pressure. Software can read and rewrite the polarity bytes. It can clear pending flags, and it can also set them to raise a request from software. A transition that arrives while a polarity register is being written is dropped on purpose, so that changing the polarity never creates a spurious event. Wake-up lines are expected to be low while reset is held.

Top module: `wkup_ctrl`

## Requirements
- R1: After reset, all four registers read 0x00 and `wake_irq_o` is 0.
- R2: Register map by `reg_addr`: 0 = polarity for lines 15..8, 1 = polarity for lines 7..0, 2 = pending for lines 15..8, 3 = pending for lines 7..0. Bit i of a high byte is line 8+i. Bit i of a low byte is line i. Reads are combinational and change no state.
- R3: A polarity bit of 0 arms its line for a falling transition, and a 1 arms it for a rising transition. The transition in the other direction leaves the pending bit unchanged.
- R4: Suppose an input changes between clock edges and no register write is active. The armed line's pending bit then reads 1 after the third rising edge that follows, and still reads 0 after the second.
- R5: A pending bit that is 1 stays 1 until a write to its pending register clears it.
- R6: A write to a pending register loads the written byte into it. A 0 clears a flag and a 1 sets it as a software request.
- R7: If a hardware event and a pending write that clears the same bit land on the same edge, the bit ends up 1.
- R8: On any edge where a polarity register is written, hardware events on all lines are discarded, and no pending bit changes on that edge.
- R9: `wake_irq_o` is registered. It equals the OR of all pending bits and updates on the same edge as those bits.
- R10: A write to a polarity register is read back unchanged and does not by itself change any pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wake_i | input | 16 | Asynchronous wake-up lines |
| reg_addr | input | 2 | Register select |
| reg_we | input | 1 | Write strobe, acts on the rising edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| wake_irq_o | output | 1 | Registered request, OR of pending flags |

## Verification
A wrong synchronizer depth or a wrong history register moves the set of a pending bit off the third edge, and the read of that byte on the following low phase shows it. A polarity bit stored inverted makes a line fire on the wrong transition, and the wrong pending byte shows it three cycles after the stimulus. A dropped or mis-merged hardware event during a pending write or polarity write appears in the next read of that byte. A bit in the request register that disagrees with the OR of the flags shows on `wake_irq_o` within one cycle, which the random phase compares every cycle.

// File: rtl/wkup_pkg.sv
package wkup_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] wk_byte_t;
endpackage

// File: rtl/wkup_sync_edge.sv
module wkup_sync_edge #(
  parameter int unsigned N_LINES     = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] async_i,
  output logic [N_LINES-1:0] rise_o,
  output logic [N_LINES-1:0] fall_o
);
  logic [N_LINES-1:0] sync_q [SYNC_STAGES];
  logic [N_LINES-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(SYNC_STAGES); i++) sync_q[i] <= '0;
      prev_q <= '0;
    end else begin
      sync_q[0] <= async_i;
      for (int i = 1; i < int'(SYNC_STAGES); i++) sync_q[i] <= sync_q[i-1];
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign rise_o = sync_q[SYNC_STAGES-1] & ~prev_q;
  assign fall_o = ~sync_q[SYNC_STAGES-1] & prev_q;

  // R3
  rise_follows_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_o != '0) |=> ((prev_q & $past(rise_o)) == $past(rise_o)));
endmodule

// File: rtl/wkup_pending.sv
module wkup_pending #(
  parameter int unsigned N_LINES = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] hw_set_i,
  input  logic [N_LINES-1:0] wr_mask_i,
  input  logic [N_LINES-1:0] wr_val_i,
  output logic [N_LINES-1:0] pend_o,
  output logic [N_LINES-1:0] pend_next_o
);
  logic [N_LINES-1:0] pend_q;
  logic               any_wr;

  assign any_wr      = |wr_mask_i;
  assign pend_next_o = ((wr_mask_i & wr_val_i) | (~wr_mask_i & pend_q)) | hw_set_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_next_o;
  end

  assign pend_o = pend_q;

  // R5
  pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !any_wr |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

  // R7
  hw_set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_set_i != '0) |=> ((pend_q & $past(hw_set_i)) == $past(hw_set_i)));
endmodule

// File: rtl/wkup_regbank.sv
module wkup_regbank
  import wkup_pkg::*;
#(
  parameter int unsigned N_LINES = 16,
  parameter int unsigned ADDR_W  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_we,
  input  wk_byte_t           reg_wdata,
  input  logic [N_LINES-1:0] pend_i,
  output logic [N_LINES-1:0] pol_o,
  output logic               trig_wr_o,
  output logic [N_LINES-1:0] pend_mask_o,
  output logic [N_LINES-1:0] pend_val_o,
  output wk_byte_t           reg_rdata
);
  localparam int unsigned N_BYTES = N_LINES / BYTE_W;

  logic [N_LINES-1:0] pol_q;

  // Polarity bytes: byte b sits at address N_BYTES-1-b (high byte first).
  for (genvar b = 0; b < int'(N_BYTES); b++) begin : g_pol
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pol_q[b*BYTE_W +: BYTE_W] <= '0;
      else if (reg_we && reg_addr == ADDR_W'(N_BYTES-1-b))
        pol_q[b*BYTE_W +: BYTE_W] <= reg_wdata;
    end
  end

  assign trig_wr_o = reg_we && (reg_addr < ADDR_W'(N_BYTES));
  assign pol_o     = pol_q;

  always_comb begin
    pend_mask_o = '0;
    pend_val_o  = '0;
    reg_rdata   = '0;
    for (int b = 0; b < int'(N_BYTES); b++) begin
      if (reg_addr == ADDR_W'(N_BYTES-1-b))
        reg_rdata = pol_q[b*BYTE_W +: BYTE_W];
      if (reg_addr == ADDR_W'(2*N_BYTES-1-b)) begin
        reg_rdata = pend_i[b*BYTE_W +: BYTE_W];
        if (reg_we) begin
          pend_mask_o[b*BYTE_W +: BYTE_W] = '1;
          pend_val_o[b*BYTE_W +: BYTE_W]  = reg_wdata;
        end
      end
    end
  end

  // R10
  pol_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_wr_o |=> $stable(pol_q));
endmodule

// File: rtl/wkup_ctrl.sv
module wkup_ctrl
  import wkup_pkg::*;
#(
  parameter int unsigned N_LINES     = 16,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned N_BYTES    = N_LINES / BYTE_W,
  localparam int unsigned ADDR_W     = $clog2(2 * N_BYTES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_LINES-1:0]  wake_i,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic                reg_we,
  input  logic [BYTE_W-1:0]   reg_wdata,
  output logic [BYTE_W-1:0]   reg_rdata,
  output logic                wake_irq_o
);
  logic [N_LINES-1:0] rise, fall, pol, hw_set;
  logic [N_LINES-1:0] pend_q, pend_next, pend_mask, pend_val;
  logic               trig_wr;
  logic               irq_q;

  wkup_sync_edge #(.N_LINES(N_LINES), .SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .async_i(wake_i), .rise_o(rise), .fall_o(fall)
  );

  wkup_regbank #(.N_LINES(N_LINES), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .pend_i(pend_q), .pol_o(pol), .trig_wr_o(trig_wr),
    .pend_mask_o(pend_mask), .pend_val_o(pend_val), .reg_rdata(reg_rdata)
  );

  // Events are discarded on any edge that rewrites a polarity byte.
  assign hw_set = trig_wr ? '0 : ((pol & rise) | (~pol & fall));

  wkup_pending #(.N_LINES(N_LINES)) u_pend (
    .clk(clk), .rst_n(rst_n), .hw_set_i(hw_set), .wr_mask_i(pend_mask),
    .wr_val_i(pend_val), .pend_o(pend_q), .pend_next_o(pend_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |pend_next;
  end

  assign wake_irq_o = irq_q;

  // R9
  irq_matches_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q == (|pend_q));

  // R8
  trig_write_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_wr |=> (pend_q == $past(pend_q)));
endmodule

// File: tb/wkup_ctrl_tb.sv
`timescale 1ns/100ps
module wkup_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] wake_i = '0;
  logic [1:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        wake_irq_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wkup_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wake_i(wake_i), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .wake_irq_o(wake_irq_o)
  );

  // Requirement-level reference model, stepped on each rising edge.
  logic [15:0] m_s1, m_s2, m_prev, m_pol, m_pend;
  always @(posedge clk or negedge rst_n) begin
    logic [15:0] ev, nxt;
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_prev = '0; m_pol = '0; m_pend = '0;
    end else begin
      ev = (m_pol & m_s2 & ~m_prev) | (~m_pol & ~m_s2 & m_prev);
      if (reg_we && reg_addr < 2'd2) ev = '0;
      nxt = m_pend;
      if (reg_we && reg_addr == 2'd2) nxt[15:8] = reg_wdata;
      if (reg_we && reg_addr == 2'd3) nxt[7:0]  = reg_wdata;
      nxt = nxt | ev;
      if (reg_we && reg_addr == 2'd0) m_pol[15:8] = reg_wdata;
      if (reg_we && reg_addr == 2'd1) m_pol[7:0]  = reg_wdata;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = wake_i; m_pend = nxt;
    end
  end

  function automatic logic [7:0] model_reg(input logic [1:0] a);
    case (a)
      2'd0:    return m_pol[15:8];
      2'd1:    return m_pol[7:0];
      2'd2:    return m_pend[15:8];
      default: return m_pend[7:0];
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    reg_addr = a;
    #0.2;
    v = reg_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  // Toggle a line, optionally write on the edge that lands its event.
  task automatic edge_ev(input int line, input logic val, input bit do_we,
                         input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wake_i[line] = val;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    if (do_we) begin reg_we = 1'b1; reg_addr = a; reg_wdata = d; end
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v); chk("R1 reset reg", v, 8'h00);
    end
    chk("R1 reset irq", {7'd0, wake_irq_o}, 8'h00);

    // R3 rising on line 3 while armed for falling: ignored
    edge_ev(3, 1'b1, 0, 2'd0, 8'h00);
    rd(2'd3, v); chk("R3 wrong direction", v, 8'h00);

    // R4 latency of a falling edge on line 3
    @(negedge clk); wake_i[3] = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rd(2'd3, v); chk("R4 not after two edges", v, 8'h00);
    @(posedge clk); @(negedge clk);
    rd(2'd3, v); chk("R4 R2 set after third edge", v, 8'h08);
    chk("R9 irq high", {7'd0, wake_irq_o}, 8'h01);

    // R5 stickiness
    repeat (6) @(negedge clk);
    rd(2'd3, v); chk("R5 sticky", v, 8'h08);

    // R6 clear and software set
    wr(2'd3, 8'h00);
    rd(2'd3, v); chk("R6 clear", v, 8'h00);
    chk("R9 irq low", {7'd0, wake_irq_o}, 8'h00);
    wr(2'd2, 8'h81);
    rd(2'd2, v); chk("R6 software set", v, 8'h81);
    chk("R9 irq sw", {7'd0, wake_irq_o}, 8'h01);
    wr(2'd2, 8'h00);

    // R10 polarity write readback, no pending change
    wr(2'd0, 8'hF0);
    rd(2'd0, v); chk("R10 readback", v, 8'hF0);
    rd(2'd2, v); chk("R10 pend unchanged", v, 8'h00);

    // R3 rising on line 12 with polarity 1
    edge_ev(12, 1'b1, 0, 2'd0, 8'h00);
    rd(2'd2, v); chk("R3 R2 rising line12", v, 8'h10);

    // R7 event on line 13 coincides with clearing pending high
    edge_ev(13, 1'b1, 1, 2'd2, 8'h00);
    rd(2'd2, v); chk("R7 event wins over clear", v, 8'h20);

    // R8 events dropped during polarity writes
    edge_ev(14, 1'b1, 1, 2'd1, 8'h00);
    rd(2'd2, v); chk("R8 drop line14", v, 8'h20);
    edge_ev(15, 1'b1, 1, 2'd0, 8'hF0);
    rd(2'd2, v); chk("R8 drop line15", v, 8'h20);
    edge_ev(0, 1'b1, 0, 2'd0, 8'h00);
    edge_ev(0, 1'b0, 1, 2'd0, 8'hF0);
    rd(2'd3, v); chk("R8 drop line0", v, 8'h00);
    chk("R9 irq after drops", {7'd0, wake_irq_o}, 8'h01);

    wr(2'd2, 8'h00);
    wr(2'd3, 8'h00);

    // Random phase against the model (R2 R3 R5 R6 R7 R8 R9 R10)
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      reg_we = 1'b0;
      chk("R9 irq random", {7'd0, wake_irq_o}, {7'd0, |m_pend});
      if (i % 40 == 0) begin
        for (int a = 0; a < 4; a++) begin
          rd(a[1:0], v); chk("R2 random read", v, model_reg(a[1:0]));
        end
      end
      for (int l = 0; l < 16; l++) if ($urandom % 10 == 0) wake_i[l] = ~wake_i[l];
      if ($urandom % 5 == 0) begin
        reg_we = 1'b1;
        reg_addr = 2'($urandom % 4);
        reg_wdata = ($urandom % 3 == 0) ? 8'h00 : 8'($urandom);
      end
    end
    @(negedge clk);
    reg_we = 1'b0;
    @(negedge clk);
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v); chk("R2 final read", v, model_reg(a[1:0]));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule